// File: doc/BRIEF.md
# Serial-Grant Bus Arbiter

This block decides which of several masters may drive a shared bus. Every master raises its own request. The requests are merged into one request line towards a central controller. When the bus is free and that line is high, the controller launches a single grant pulse into a chain of pass-through stages. Stage 0 has the highest priority and the last stage has the lowest. A stage whose master is requesting keeps the grant. A stage whose master is not requesting hands the grant to the next stage within the same cycle.

The master that caught the grant owns the bus until it raises the shared release line. The controller then returns to idle and can launch a new grant no sooner than the cycle after that. The block makes no attempt at fairness: a master at a high position that keeps requesting can shut out every master below it indefinitely. Grant and busy outputs come from registers.

Top module: `daisy_arb`

## Requirements
- R1: After a synchronous reset, every bit of `grant` is 0 and `busy` is 0.
- R2: In a cycle with `busy` low and at least one `req` bit set, the next cycle has `busy` high and `grant` one-hot on the lowest-index requesting master. Bit 0 is the highest priority.
- R3: In every cycle at most one `grant` bit is set, and `busy` is high exactly when one `grant` bit is set.
- R4: While `busy` is high and `release_i` is low, `grant` holds its value. This holds when other masters, including higher-priority ones, start requesting, and when the owner drops its own request.
- R5: A cycle with `busy` high and `release_i` high is followed by a cycle with `grant` all 0 and `busy` 0. A new grant can appear at the earliest one cycle after that.
- R6: `release_i` raised while `busy` is low has no effect: `grant` and `busy` follow R2 and R7 as if `release_i` were low.
- R7: In a cycle with `busy` low and no `req` bit set, the next cycle has `busy` low and `grant` all 0.
- R8: No fairness is enforced. If a higher-priority master requests at every idle cycle, a lower-priority master that keeps requesting is never granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N_MASTERS | Request from each master, bit 0 highest priority |
| release_i | input | 1 | Shared release line, raised by the owner to hand back the bus |
| grant | output | N_MASTERS | Registered one-hot grant to the owning master |
| busy | output | 1 | Registered flag, high while the bus is owned |

## Verification
Requests are applied one master at a time and in overlapping sets. The single-master cases show that the grant reaches the tail of the chain. The overlapping sets show that the first requester from the top absorbs the grant. Requests that change while the bus is owned, including a new higher-priority request and the owner dropping its request, separate a held grant from one that is recomputed. Releases are placed while the bus is owned, while it is idle, and back to back with waiting requests, so that the timing of the idle gap can be checked. A long random mix, compared every cycle against a behavioural model, also covers the starvation pattern of a high master that requests repeatedly.

// File: rtl/daisy_arb_pkg.sv
package daisy_arb_pkg;
  typedef enum logic {BUS_IDLE = 1'b0, BUS_OWNED = 1'b1} bus_state_e;
endpackage

// File: rtl/req_merge.sv
module req_merge #(
  parameter int N_MASTERS = 4
) (
  input  logic [N_MASTERS-1:0] req,
  output logic                 any_req
);
  // Shared request line: wired-OR of all masters
  assign any_req = |req;
endmodule

// File: rtl/chain_link.sv
module chain_link (
  input  logic grant_in,
  input  logic req,
  output logic take,
  output logic grant_out
);
  // Requesting stage absorbs the grant, otherwise passes it on this cycle
  assign take      = grant_in & req;
  assign grant_out = grant_in & ~req;
endmodule

// File: rtl/bus_ctrl.sv
module bus_ctrl
  import daisy_arb_pkg::*;
#(
  parameter int N_MASTERS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 any_req,
  input  logic                 release_i,
  input  logic [N_MASTERS-1:0] take,
  input  logic                 tail_grant,
  output logic                 chain_grant,
  output logic [N_MASTERS-1:0] grant_q,
  output logic                 busy
);
  bus_state_e state_q;

  // Grant is launched only from idle; ownership blocks new launches
  assign chain_grant = (state_q == BUS_IDLE) && any_req;
  assign busy        = (state_q == BUS_OWNED);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= BUS_IDLE;
      grant_q <= '0;
    end else begin
      case (state_q)
        BUS_IDLE: begin
          if (chain_grant && !tail_grant) begin
            state_q <= BUS_OWNED;
            grant_q <= take;
          end
        end
        BUS_OWNED: begin
          if (release_i) begin
            state_q <= BUS_IDLE;
            grant_q <= '0;
          end
        end
        default: begin
          state_q <= BUS_IDLE;
          grant_q <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/daisy_arb.sv
module daisy_arb #(
  parameter int N_MASTERS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_MASTERS-1:0] req,
  input  logic                 release_i,
  output logic [N_MASTERS-1:0] grant,
  output logic                 busy
);
  logic                 any_req;
  logic                 chain_grant;
  logic [N_MASTERS:0]   thread;
  logic [N_MASTERS-1:0] take;

  req_merge #(.N_MASTERS(N_MASTERS)) u_merge (
    .req     (req),
    .any_req (any_req)
  );

  assign thread[0] = chain_grant;

  // One pass-through stage per master, highest priority first
  for (genvar i = 0; i < N_MASTERS; i++) begin : g_link
    chain_link u_link (
      .grant_in  (thread[i]),
      .req       (req[i]),
      .take      (take[i]),
      .grant_out (thread[i+1])
    );
  end

  bus_ctrl #(.N_MASTERS(N_MASTERS)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .any_req     (any_req),
    .release_i   (release_i),
    .take        (take),
    .tail_grant  (thread[N_MASTERS]),
    .chain_grant (chain_grant),
    .grant_q     (grant),
    .busy        (busy)
  );
endmodule

// File: rtl/daisy_arb_checker.sv
module daisy_arb_checker #(
  parameter int N_MASTERS = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic [N_MASTERS-1:0] req,
  input logic                 release_i,
  input logic [N_MASTERS-1:0] grant,
  input logic                 busy
);
  logic [N_MASTERS-1:0] above_mask;
  assign above_mask = grant - {{(N_MASTERS-1){1'b0}}, 1'b1};

  // R1
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (grant == '0) && !busy);
  // R3
  p_onehot_r3: assert property (@(posedge clk) disable iff (rst) $onehot0(grant));
  p_busy_match_r3: assert property (@(posedge clk) disable iff (rst) busy == (grant != '0));
  // R2
  p_win_requested_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && (req != '0)) |=> busy && ((grant & $past(req)) == grant));
  p_win_highest_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && (req != '0)) |=> ((above_mask & $past(req)) == '0));
  // R4
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && !release_i) |=> $stable(grant) && busy);
  // R5
  p_release_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && release_i) |=> !busy && (grant == '0));
  // R7
  p_stay_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (!busy && (req == '0)) |=> !busy);
endmodule

bind daisy_arb daisy_arb_checker #(.N_MASTERS(N_MASTERS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req       (req),
  .release_i (release_i),
  .grant     (grant),
  .busy      (busy)
);

// File: tb/daisy_arb_test.sv
module daisy_arb_test;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] req = '0;
  logic         release_i = 1'b0;
  logic [N-1:0] grant;
  logic         busy;

  int    checks = 0;
  int    failures = 0;
  string cur_tag = "R1";
  bit    done = 1'b0;

  // Reference model state
  bit    m_busy = 1'b0;
  int    m_owner = -1;

  always #2 clk = ~clk;

  daisy_arb #(.N_MASTERS(N)) uut (
    .clk(clk), .rst(rst), .req(req), .release_i(release_i),
    .grant(grant), .busy(busy)
  );

  // Behavioural model: idle -> first requester from bit 0; owned -> wait for release
  always @(posedge clk) begin
    if (rst) begin
      m_busy = 1'b0;
      m_owner = -1;
    end else if (m_busy) begin
      if (release_i) begin
        m_busy = 1'b0;
        m_owner = -1;
      end
    end else if (req != '0) begin
      m_owner = -1;
      for (int i = N - 1; i >= 0; i--) if (req[i]) m_owner = i;
      m_busy = 1'b1;
    end
  end

  function automatic logic [N-1:0] exp_grant();
    logic [N-1:0] g = '0;
    if (m_busy) g[m_owner] = 1'b1;
    return g;
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (grant !== exp_grant() || busy !== m_busy) begin
        failures++;
        $display("FAIL %s: grant=%b busy=%b expected grant=%b busy=%b at %0t",
                 cur_tag, grant, busy, exp_grant(), m_busy, $time);
      end
    end
  end

  task automatic drive(input logic [N-1:0] r, input logic rel, input int cycles);
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      #1;
      req = r;
      release_i = rel;
    end
  endtask

  int low_wins = 0;

  initial begin
    cur_tag = "R1";
    drive(4'b0000, 1'b0, 3);
    drive(4'b0000, 1'b0, 1);
    rst = 1'b0;
    cur_tag = "R7";
    drive(4'b0000, 1'b0, 4);
    cur_tag = "R2";
    drive(4'b0110, 1'b0, 3);     // master 1 wins
    cur_tag = "R4";
    drive(4'b1111, 1'b0, 3);     // higher master 0 arrives, held
    drive(4'b0000, 1'b0, 3);     // owner drops request, held
    cur_tag = "R5";
    drive(4'b1000, 1'b1, 1);     // release with master 3 waiting
    drive(4'b1000, 1'b0, 4);     // idle gap then master 3 (chain tail)
    drive(4'b0000, 1'b1, 1);
    cur_tag = "R6";
    drive(4'b0000, 1'b1, 4);     // release while idle
    drive(4'b0100, 1'b1, 1);     // request plus release while idle
    drive(4'b0000, 1'b0, 3);
    drive(4'b0000, 1'b1, 1);
    cur_tag = "R8";
    for (int k = 0; k < 20; k++) begin
      drive(4'b1001, 1'b0, 2);
      drive(4'b1001, 1'b1, 1);
      if (grant[3]) low_wins++;
    end
    drive(4'b0000, 1'b1, 2);
    checks++;
    if (low_wins != 0) begin
      failures++;
      $display("FAIL R8: low master granted %0d times, expected 0", low_wins);
    end
    cur_tag = "R3";
    for (int k = 0; k < 400; k++) begin
      drive(N'($urandom), ($urandom % 3) == 0, 1);
      if (!$onehot0(grant) || busy != (grant != '0)) begin
        checks++;
        failures++;
        $display("FAIL R3: grant=%b busy=%b expected onehot0 and matching busy", grant, busy);
      end
    end
    cur_tag = "R1";
    rst = 1'b1;
    drive(4'b1111, 1'b0, 2);
    rst = 1'b0;
    drive(4'b0000, 1'b0, 2);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule